// File: doc/BRIEF.md
# Threshold-Armed Single-Bit Fault Injector

This block is an evaluation harness placed beside an iterative block-cipher core to measure how the core stands up to fault analysis. It samples a 12-bit on-die thermal sensor code and becomes armed when two upper bits of that code go from "not both set" to "both set". The armed state is held in one flop and survives the code cooling down again.

Once armed, the harness waits for the round counter to equal a chosen target round. In that cycle it inverts one chosen bit of the state word entering the substitution layer, and it does this once only. From the next cycle on it forces the core's plaintext load enable low. The core therefore runs its next encryption on the same plaintext without a fault, which gives a faulty and a correct ciphertext for one input. A synchronous clear drops both the armed flop and the load hold. A new rising edge of the sensor condition is then needed to arm again.

Top module: `fi_bit_injector`

## Requirements
- R1: While rst_ni is low, and after reset until armed, state_o equals state_i on every bit and load_en_o equals load_en_i.
- R2: The harness arms on the clock edge at which sensor_code_i bits 9 and 8 are both 1 and were not both 1 at the previous edge (for example 0x977 then 0xB00). Codes with only one of the two bits set, such as 0xA00 or 0x900, never arm it.
- R3: Once armed, the harness stays armed when the sensor code falls back below the threshold, until clear_i is applied.
- R4: When armed and round_i equals the target round (27), state_o equals state_i with bit 32 inverted and all other bits passed through. In any other round, state_o equals state_i.
- R5: At most one inversion is made per arming. After the injection cycle, state_o equals state_i again, even if round_i stays at or returns to the target round, until clear_i.
- R6: From the cycle after the injection until clear_i, load_en_o is 0 whatever load_en_i is. In the injection cycle itself, and otherwise, load_en_o equals load_en_i.
- R7: clear_i is synchronous and wins over a simultaneous arming edge or injection: on the next cycle the harness is unarmed and the load is released. A sensor condition that stays high does not re-arm it; a new rising edge is needed.
- R8: With a round-based core around it, ciphertexts are unchanged while the harness is unarmed. After arming, exactly one encryption gives a faulty ciphertext. The following encryption reuses that plaintext and gives its correct ciphertext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous disarm and load release |
| sensor_code_i | input | 12 | Thermal sensor code |
| round_i | input | 6 | Current round of the cipher core |
| state_i | input | 64 | Substitution-layer input from the core |
| load_en_i | input | 1 | Plaintext load enable from the core control |
| state_o | output | 64 | Substitution-layer input, possibly with one bit inverted |
| load_en_o | output | 1 | Plaintext load enable to the core, held low after injection |

## Verification
The bench builds the harness with its defaults: a 12-bit code armed on bits 9 and 8, target round 27 of a 6-bit counter, and bit 32 of a 64-bit word. A port-level vector walk covers arming edges, non-arming codes, sticky arming, clear priority and the one-shot load hold. A small bench-side 32-round toy cipher then drives round_i and state_i from the harness itself. With these values the full flow comes within reach: an unchanged ciphertext, a faulty/correct pair on a reused plaintext, and a fresh load after clear.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int unsigned DEF_CODE_W    = 12;
  localparam int unsigned DEF_ARM_HI    = 9;
  localparam int unsigned DEF_ARM_LO    = 8;
  localparam int unsigned DEF_ROUND_W   = 6;
  localparam int unsigned DEF_TARGET    = 27;
  localparam int unsigned DEF_STATE_W   = 64;
  localparam int unsigned DEF_FLIP_BIT  = 32;

  function automatic logic pair_hot(input logic hi, input logic lo);
    return hi & lo;
  endfunction
endpackage

// File: rtl/fi_arm_trigger.sv
module fi_arm_trigger #(
  parameter int unsigned CODE_W = fi_pkg::DEF_CODE_W,
  parameter int unsigned ARM_HI = fi_pkg::DEF_ARM_HI,
  parameter int unsigned ARM_LO = fi_pkg::DEF_ARM_LO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              armed_o
);
  logic hot;
  logic hot_q;
  logic armed_q;

  assign hot = fi_pkg::pair_hot(code_i[ARM_HI], code_i[ARM_LO]);

  // edge sampler keeps running through clear so a held-high code cannot re-arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      hot_q <= hot;
      if (clear_i)            armed_q <= 1'b0;
      else if (hot && !hot_q) armed_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;

  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !clear_i) |=> armed_q); // R3
  AST_ARM_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> ($past(hot) && !$past(hot_q))); // R2
  AST_ARM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !armed_q); // R7
endmodule

// File: rtl/fi_round_gate.sv
module fi_round_gate #(
  parameter int unsigned ROUND_W = fi_pkg::DEF_ROUND_W,
  parameter int unsigned TARGET  = fi_pkg::DEF_TARGET
) (
  input  logic [ROUND_W-1:0] round_i,
  input  logic               armed_i,
  input  logic               spent_i,
  output logic               fire_o
);
  localparam logic [ROUND_W-1:0] TGT = ROUND_W'(TARGET);

  logic round_hit;
  assign round_hit = (round_i == TGT);
  assign fire_o    = armed_i & round_hit & ~spent_i;
endmodule

// File: rtl/fi_load_hold.sv
module fi_load_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic fire_i,
  input  logic load_en_i,
  output logic load_en_o,
  output logic spent_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= 1'b0;
    else if (clear_i) hold_q <= 1'b0;
    else if (fire_i)  hold_q <= 1'b1;
  end

  assign load_en_o = load_en_i & ~hold_q;
  assign spent_o   = hold_q;

  AST_HOLD_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !clear_i) |=> !load_en_o); // R6
  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (load_en_o == load_en_i)); // R7
endmodule

// File: rtl/fi_bit_payload.sv
module fi_bit_payload #(
  parameter int unsigned STATE_W  = fi_pkg::DEF_STATE_W,
  parameter int unsigned FLIP_BIT = fi_pkg::DEF_FLIP_BIT
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic               fire_i,
  output logic [STATE_W-1:0] state_o
);
  for (genvar g = 0; g < STATE_W; g++) begin : g_bit
    if (g == FLIP_BIT) begin : g_tap
      assign state_o[g] = state_i[g] ^ fire_i;
    end else begin : g_pass
      assign state_o[g] = state_i[g];
    end
  end
endmodule

// File: rtl/fi_bit_injector.sv
module fi_bit_injector #(
  parameter int unsigned CODE_W   = fi_pkg::DEF_CODE_W,
  parameter int unsigned ARM_HI   = fi_pkg::DEF_ARM_HI,
  parameter int unsigned ARM_LO   = fi_pkg::DEF_ARM_LO,
  parameter int unsigned ROUND_W  = fi_pkg::DEF_ROUND_W,
  parameter int unsigned TARGET   = fi_pkg::DEF_TARGET,
  parameter int unsigned STATE_W  = fi_pkg::DEF_STATE_W,
  parameter int unsigned FLIP_BIT = fi_pkg::DEF_FLIP_BIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [CODE_W-1:0]  sensor_code_i,
  input  logic [ROUND_W-1:0] round_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               load_en_i,
  output logic [STATE_W-1:0] state_o,
  output logic               load_en_o
);
  localparam logic [ROUND_W-1:0] TGT = ROUND_W'(TARGET);

  logic armed;
  logic spent;
  logic fire;

  fi_arm_trigger #(.CODE_W(CODE_W), .ARM_HI(ARM_HI), .ARM_LO(ARM_LO)) u_trig (
    .clk_i, .rst_ni, .clear_i, .code_i(sensor_code_i), .armed_o(armed)
  );

  fi_round_gate #(.ROUND_W(ROUND_W), .TARGET(TARGET)) u_gate (
    .round_i, .armed_i(armed), .spent_i(spent), .fire_o(fire)
  );

  fi_load_hold u_hold (
    .clk_i, .rst_ni, .clear_i, .fire_i(fire), .load_en_i, .load_en_o, .spent_o(spent)
  );

  fi_bit_payload #(.STATE_W(STATE_W), .FLIP_BIT(FLIP_BIT)) u_pay (
    .state_i, .fire_i(fire), .state_o
  );

  AST_SINGLE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o ^ state_i) <= 1); // R4
  AST_OFF_ROUND_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (round_i != TGT) |-> (state_o == state_i)); // R4
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o != state_i) && !clear_i) |=> (state_o == state_i)); // R5
  AST_UNARMED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> ((state_o == state_i) && (load_en_o == load_en_i || spent))); // R1
endmodule

// File: tb/fi_bit_injector_bench.sv
`timescale 1ns/1ps
module fi_bit_injector_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic [11:0] sensor_code_i = 12'h977;
  logic [5:0]  round_i = '0;
  logic [63:0] state_i = '0;
  logic        load_en_i = 1'b0;
  logic [63:0] state_o;
  logic        load_en_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [63:0] BASE = 64'hA5C3_0F1E_7B2D_9468;

  // {code, round, bit32 in, load in, clear, exp bit32, exp load}
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {12'h977, 6'd27, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {12'hB00, 6'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {12'hB00, 6'd26, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {12'h977, 6'd27, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {12'h977, 6'd27, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {12'h977, 6'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {12'hB00, 6'd27, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {12'hB00, 6'd27, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {12'hB00, 6'd27, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {12'hA00, 6'd27, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {12'h900, 6'd27, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {12'hF00, 6'd27, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {12'hF00, 6'd27, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {12'h000, 6'd27, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {12'h000, 6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  function automatic string vec_req(input int i);
    case (i)
      0:       return "R1";
      1, 9, 10: return "R2";
      2, 3:    return "R4/R3";
      4:       return "R5/R6";
      5, 13:   return "R6";
      12:      return "R4/R6";
      default: return "R7";
    endcase
  endfunction

  fi_bit_injector u_fi_bit_injector (
    .clk_i(clk), .rst_ni, .clear_i, .sensor_code_i, .round_i,
    .state_i, .load_en_i, .state_o, .load_en_o
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] round_fn(input logic [63:0] s, input int r);
    return {s[56:0], s[63:57]} ^ (s >> 5) ^ 64'(r * 32'h9E37);
  endfunction

  function automatic logic [63:0] enc_ref(input logic [63:0] pt, input bit flip);
    logic [63:0] s = pt;
    for (int r = 1; r <= 32; r++) begin
      if (flip && r == 27) s[32] = ~s[32];
      s = round_fn(s, r);
    end
    return s;
  endfunction

  logic [63:0] plain_q = '0;

  // bench-side toy core: load cycle then 32 rounds through the harness
  task automatic run_enc(input logic [63:0] pt, output logic [63:0] ct);
    logic [63:0] s;
    logic        ld;
    @(negedge clk);
    load_en_i = 1'b1; round_i = '0; state_i = pt;
    #1 ld = load_en_o;
    @(posedge clk);
    if (ld) plain_q = pt;
    s = plain_q;
    for (int r = 1; r <= 32; r++) begin
      @(negedge clk);
      load_en_i = 1'b0; round_i = 6'(r); state_i = s;
      #1 s = round_fn(state_o, r);
      @(posedge clk);
    end
    ct = s;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      load_en_i = 1'b0; round_i = '0; clear_i = 1'b0;
    end
  endtask

  initial begin
    logic [63:0] ct_a, ct_b, ct_c, ct_d;
    logic [63:0] p2;
    // R1 during reset
    state_i = BASE; load_en_i = 1'b1; round_i = 6'd27;
    #12;
    check("R1 reset state", state_o, BASE);
    check("R1 reset load", {63'd0, load_en_o}, 64'd1);
    @(negedge clk); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [63:0] s_in, s_exp;
      @(negedge clk);
      sensor_code_i = VEC[i][22:11];
      round_i       = VEC[i][10:5];
      s_in          = BASE; s_in[32] = VEC[i][4];
      s_exp         = BASE; s_exp[32] = VEC[i][1];
      state_i       = s_in;
      load_en_i     = VEC[i][3];
      clear_i       = VEC[i][2];
      #1;
      check(vec_req(i), state_o, s_exp);
      check(vec_req(i), {63'd0, load_en_o}, {63'd0, VEC[i][0]});
    end

    // end-to-end with toy core, R8
    @(negedge clk); rst_ni = 1'b0; clear_i = 1'b0; sensor_code_i = 12'h977;
    @(negedge clk); rst_ni = 1'b1;
    run_enc(64'h0123_4567_89AB_CDEF, ct_a);
    check("R8 unarmed ct", ct_a, enc_ref(64'h0123_4567_89AB_CDEF, 1'b0));
    @(negedge clk); sensor_code_i = 12'hB00;
    idle(2);
    p2 = 64'hFEED_FACE_DEAD_BEEF;
    run_enc(p2, ct_b);
    check("R8 faulty ct", ct_b, enc_ref(p2, 1'b1));
    run_enc(64'h1111_2222_3333_4444, ct_c);
    check("R8 reused plaintext", plain_q, p2);
    check("R8 correct ct of pair", ct_c, enc_ref(p2, 1'b0));
    check("R8 pair differs", {63'd0, ct_b != ct_c}, 64'd1);
    @(negedge clk); clear_i = 1'b1;
    idle(1);
    run_enc(64'h5555_6666_7777_8888, ct_d);
    check("R7 load after clear", plain_q, 64'h5555_6666_7777_8888);
    check("R7 no re-arm while hot", ct_d, enc_ref(64'h5555_6666_7777_8888, 1'b0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule